// File: doc/BRIEF.md
# Signed Iterative Integer Divider

This block divides a signed two's-complement dividend of twice the operand width by a signed operand-width divisor. It produces a quotient truncated toward zero and a remainder that carries the dividend's sign. The operand width is chosen per operation from 8, 16, 32 or 64 bits. The datapath works on magnitudes and retires one quotient bit per clock. The signs are applied once the loop ends.

A requester presents the operands and pulses `start` while `busy` is low. The block captures everything on that edge and raises `busy`. At the end it pulses `done` for one cycle. On that cycle either new results are on `quot`/`rem`, or `div_err` is high and the previous results are kept. A zero divisor or a quotient outside the signed range of the operand width raises `div_err`. In 8-bit mode the result is also given as a packed 16-bit word, with the remainder in the high byte and the quotient in the low byte.

Top module: `sdiv_iter`

## Requirements
- R1: The quotient is the exact signed quotient truncated toward zero (-17 / 5 gives -3). It appears on `quot` sign-extended to 64 bits.
- R2: The remainder satisfies dividend = quotient * divisor + remainder. It is nonzero only with the dividend's sign, and it appears on `rem` sign-extended to 64 bits (50 / -7 gives quotient -7, remainder 1).
- R3: In 8-bit mode `byte_res` holds the remainder in bits 15:8 and the quotient in bits 7:0.
- R4: The signed extremes are legal results with no error. Examples: -128 / 1 and 127 / 1 in 8-bit mode, and -2^63 / 1 in 64-bit mode.
- R5: A zero divisor gives `div_err` = 1 on the `done` cycle, and `quot`, `rem` and `byte_res` keep their previous values.
- R6: A quotient below -2^(N-1) or above 2^(N-1)-1, where N is the operand width, gives `div_err` = 1 and leaves the results unchanged. Examples: -128 / -1 in 8-bit mode, or a high dividend half whose magnitude is at least the divisor's.
- R7: `busy` is high from the cycle after an accepted start until the cycle on which `done` rises. `done` is a one-cycle pulse while `busy` is low. It comes no later than the (N+2)th rising edge after the start edge, or the 2nd edge for a zero divisor or an early-detected overflow.
- R8: `start` while `busy` is high is ignored. It produces no extra `done` and does not alter the operation in progress.
- R9: While `rst_n` is low at a rising edge, the block clears `busy`, `done`, `div_err`, `quot`, `rem` and `byte_res`.
- R10: `size_sel` encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = 64-bit. In 8-bit mode the dividend is `dvd_lo[15:0]`; in the other modes it is `{dvd_hi[N-1:0], dvd_lo[N-1:0]}`. The divisor is `dvsr[N-1:0]`. Input bits above these fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only while busy is low) |
| size_sel | input | 2 | Operand width select (R10 encoding) |
| dvd_hi | input | 64 | Upper half of the dividend (16/32/64-bit modes) |
| dvd_lo | input | 64 | Lower half of the dividend; bits 15:0 are the whole dividend in 8-bit mode |
| dvsr | input | 64 | Divisor, low N bits used |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Last completed operation was a divide error |
| quot | output | 64 | Quotient, sign-extended |
| rem | output | 64 | Remainder, sign-extended |
| byte_res | output | 16 | 8-bit mode packed result {remainder, quotient} |

## Verification
A corrupted partial remainder, a shifted-in bit taken from the wrong position, or a miscounted iteration shows as a wrong `quot`/`rem` on the next `done` pulse, N+2 edges after the start. A wrong sign decision shows at the same point as a negated quotient or remainder. A faulty range or zero-divisor decision shows as a mismatched `div_err`, or as results that change when they should have been held. A stuck sequencer shows as `busy` that never falls or as a missing or extra `done` within one operation's latency. A captured operand that changes mid-run shows as a result computed from the intruding operands.

// File: rtl/sdiv_pkg.sv
// Shared types for the signed iterative divider.
// Assumes the datapath width is 64 so that every size code is reachable.
package sdiv_pkg;

    typedef enum logic [1:0] {
        OPSZ_8  = 2'd0,
        OPSZ_16 = 2'd1,
        OPSZ_32 = 2'd2,
        OPSZ_64 = 2'd3
    } opsz_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_RUN  = 2'd2,
        ST_FIN  = 2'd3
    } dstate_e;

    // Operand width in bits for a size code.
    function automatic logic [7:0] opsz_bits(input opsz_e s);
        return 8'd8 << s;
    endfunction

endpackage

// File: rtl/sdiv_prep.sv
// Operand preparation: extracts the N-bit divisor and 2N-bit dividend for the
// selected size, records their signs and produces magnitudes. The low dividend
// half is left-aligned so the core can shift it out MSB first. It also flags
// a zero divisor and the early overflow case |hi| >= |divisor|.
// Assumes W = 64; purely combinational.
module sdiv_prep
    import sdiv_pkg::*;
#(
    parameter int W = 64
) (
    input  opsz_e          size,
    input  logic [W-1:0]   dvd_hi,
    input  logic [W-1:0]   dvd_lo,
    input  logic [W-1:0]   dvsr,
    output logic           dvd_neg,
    output logic           dvs_neg,
    output logic           dvsr_zero,
    output logic           hi_ge_dvsr,
    output logic [W-1:0]   dvsr_mag,
    output logic [W-1:0]   hi_mag,
    output logic [W-1:0]   lo_aligned
);
    localparam int DW = 2 * W;

    logic [7:0]    nb;
    logic [8:0]    sh_dw;
    logic [7:0]    sh_w;
    logic [W-1:0]  lo_mask;
    logic [DW-1:0] raw, dvd_up, dvd_full, dvd_mag;
    logic [W-1:0]  dvs_up, dvs_full;

    // Assemble the dividend for the size, sign-extend it and take magnitudes.
    always_comb begin
        nb      = opsz_bits(size);
        sh_dw   = 9'(DW) - {nb, 1'b0};
        sh_w    = 8'(W) - nb;
        lo_mask = ~({W{1'b1}} << nb);
        if (size == OPSZ_8) raw = DW'(dvd_lo[15:0]);
        else                raw = (DW'(dvd_hi) << nb) | DW'(dvd_lo & lo_mask);
        dvd_up   = raw << sh_dw;
        dvd_neg  = dvd_up[DW-1];
        dvd_full = DW'($signed(dvd_up) >>> sh_dw);
        dvd_mag  = dvd_neg ? -dvd_full : dvd_full;
        hi_mag     = W'(dvd_mag >> nb);
        lo_aligned = dvd_mag[W-1:0] << sh_w;

        dvs_up   = dvsr << sh_w;
        dvs_neg  = dvs_up[W-1];
        dvs_full = W'($signed(dvs_up) >>> sh_w);
        dvsr_mag = dvs_neg ? -dvs_full : dvs_full;

        dvsr_zero  = (dvsr_mag == '0);
        hi_ge_dvsr = (hi_mag >= dvsr_mag);
    end

endmodule

// File: rtl/sdiv_core.sv
// Restoring shift-subtract core on unsigned magnitudes. A load sets the
// partial remainder to the high dividend magnitude. Each step shifts in one
// dividend bit, subtracts when it fits, and records one quotient bit.
// Assumes hi_mag < dvsr_mag at load, so the remainder always fits W bits.
module sdiv_core #(
    parameter int W = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [W-1:0]  dvsr_mag,
    input  logic [W-1:0]  hi_mag,
    input  logic [W-1:0]  lo_aligned,
    output logic [W-1:0]  q_mag,
    output logic [W-1:0]  r_mag
);
    logic [W-1:0] r_q, sh_q, q_q;
    logic [W:0]   trial;
    logic         fits;
    logic [W-1:0] diff;

    // Trial subtraction for the current step.
    always_comb begin
        trial = {r_q, sh_q[W-1]};
        fits  = (trial >= {1'b0, dvsr_mag});
        diff  = trial[W-1:0] - dvsr_mag;
    end

    // Partial remainder, dividend shifter and quotient accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q  <= '0;
            sh_q <= '0;
            q_q  <= '0;
        end else if (load) begin
            r_q  <= hi_mag;
            sh_q <= lo_aligned;
            q_q  <= '0;
        end else if (step) begin
            r_q  <= fits ? diff : trial[W-1:0];
            sh_q <= sh_q << 1;
            q_q  <= {q_q[W-2:0], fits};
        end
    end

    assign q_mag = q_q;
    assign r_mag = r_q;

    // The remainder stays below the divisor magnitude at every step (R2).
    p_rem_below_dvsr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (r_q < dvsr_mag));

endmodule

// File: rtl/sdiv_post.sv
// Sign restoration and range check. Negates the quotient magnitude when the
// operand signs differ, and the remainder magnitude when the dividend is
// negative. Flags quotient magnitudes outside the signed N-bit range.
// Purely combinational; assumes W = 64.
module sdiv_post
    import sdiv_pkg::*;
#(
    parameter int W = 64
) (
    input  opsz_e         size,
    input  logic [W-1:0]  q_mag,
    input  logic [W-1:0]  r_mag,
    input  logic          dvd_neg,
    input  logic          dvs_neg,
    output logic [W-1:0]  quot_se,
    output logic [W-1:0]  rem_se,
    output logic          range_err
);
    logic [W-1:0] lim;
    logic         q_neg;

    // Apply signs and compare against the size-dependent limit.
    always_comb begin
        lim       = W'(1) << (opsz_bits(size) - 8'd1);
        q_neg     = dvd_neg ^ dvs_neg;
        range_err = q_neg ? (q_mag > lim) : (q_mag >= lim);
        quot_se   = q_neg ? -q_mag : q_mag;
        rem_se    = dvd_neg ? -r_mag : r_mag;
    end

endmodule

// File: rtl/sdiv_iter.sv
// Top of the signed iterative divider. Captures the operands on an accepted
// start, runs one preparation cycle and N restoring steps, then writes signed
// results with a one-cycle done pulse. A divide error holds the old results.
// Assumes W = 64; synchronous active-low reset.
module sdiv_iter
    import sdiv_pkg::*;
#(
    parameter int W = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    size_sel,
    input  logic [W-1:0]  dvd_hi,
    input  logic [W-1:0]  dvd_lo,
    input  logic [W-1:0]  dvsr,
    output logic          busy,
    output logic          done,
    output logic          div_err,
    output logic [W-1:0]  quot,
    output logic [W-1:0]  rem,
    output logic [15:0]   byte_res
);
    localparam int CNTW    = $clog2(W + 1);
    localparam int LAT_MAX = W + 2;
    localparam int LATW    = $clog2(LAT_MAX + 2);

    dstate_e        state;
    opsz_e          size_q;
    logic [W-1:0]   hi_q, lo_q, dv_q;
    logic [CNTW-1:0] cnt;
    logic           done_q, err_q;
    logic [W-1:0]   quot_q, rem_q;
    logic [LATW-1:0] lat_cnt;

    logic           dvd_neg, dvs_neg, dvsr_zero, hi_ge_dvsr;
    logic [W-1:0]   dvsr_mag, hi_mag, lo_aligned, q_mag, r_mag, quot_se, rem_se;
    logic           range_err, load, step;

    sdiv_prep #(.W(W)) u_prep (
        .size(size_q), .dvd_hi(hi_q), .dvd_lo(lo_q), .dvsr(dv_q),
        .dvd_neg(dvd_neg), .dvs_neg(dvs_neg), .dvsr_zero(dvsr_zero),
        .hi_ge_dvsr(hi_ge_dvsr), .dvsr_mag(dvsr_mag), .hi_mag(hi_mag),
        .lo_aligned(lo_aligned)
    );

    sdiv_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .dvsr_mag(dvsr_mag), .hi_mag(hi_mag), .lo_aligned(lo_aligned),
        .q_mag(q_mag), .r_mag(r_mag)
    );

    sdiv_post #(.W(W)) u_post (
        .size(size_q), .q_mag(q_mag), .r_mag(r_mag),
        .dvd_neg(dvd_neg), .dvs_neg(dvs_neg),
        .quot_se(quot_se), .rem_se(rem_se), .range_err(range_err)
    );

    // Core control derived from the sequencer state.
    always_comb begin
        load = (state == ST_PREP) && !(dvsr_zero || hi_ge_dvsr);
        step = (state == ST_RUN);
    end

    // Sequencer, operand capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            size_q <= OPSZ_8;
            hi_q   <= '0;
            lo_q   <= '0;
            dv_q   <= '0;
            cnt    <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            quot_q <= '0;
            rem_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    size_q <= opsz_e'(size_sel);
                    hi_q   <= dvd_hi;
                    lo_q   <= dvd_lo;
                    dv_q   <= dvsr;
                    state  <= ST_PREP;
                end
                ST_PREP: begin
                    cnt <= '0;
                    if (dvsr_zero || hi_ge_dvsr) begin
                        err_q  <= 1'b1;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNTW'(opsz_bits(size_q) - 8'd1)) state <= ST_FIN;
                end
                ST_FIN: begin
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                    err_q  <= range_err;
                    if (!range_err) begin
                        quot_q <= quot_se;
                        rem_q  <= rem_se;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Cycles spent busy, for the latency bound check.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) lat_cnt <= '0;
        else                 lat_cnt <= lat_cnt + 1'b1;
    end

    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign div_err  = err_q;
    assign quot     = quot_q;
    assign rem      = rem_q;
    assign byte_res = {rem_q[7:0], quot_q[7:0]};

    // An accepted start makes the block busy on the next cycle (R7).
    p_busy_after_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // Done lasts exactly one cycle (R7).
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Done is only seen while idle (R7).
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // An operation never outlasts N + 2 busy cycles (R7).
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lat_cnt <= LATW'(LAT_MAX));

    // An errored completion leaves the results untouched (R5, R6).
    p_hold_on_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_err) |-> ($stable(quot) && $stable(rem)));

    // A start during busy does not disturb the captured operands (R8).
    p_ignore_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(dv_q) && $stable(hi_q) && $stable(lo_q) && $stable(size_q)));

endmodule

// File: tb/sdiv_iter_bench.sv
module sdiv_iter_bench;
    localparam int W = 64;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  sz;
        logic        err;
        logic [63:0] q;
        logic [63:0] r;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] size_sel = '0;
    logic [W-1:0] dvd_hi = '0, dvd_lo = '0, dvsr = '0;
    logic busy, done, div_err;
    logic [W-1:0] quot, rem;
    logic [15:0] byte_res;

    exp_t  sb[$];
    string tags[$];
    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] last_q = '0, last_r = '0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdiv_iter #(.W(W)) u_sdiv_iter (
        .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvsr(dvsr),
        .busy(busy), .done(done), .div_err(div_err),
        .quot(quot), .rem(rem), .byte_res(byte_res)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference: exact signed division on 128-bit values, range checked.
    function automatic exp_t model(input logic [1:0] sz, input logic [63:0] hi,
                                   input logic [63:0] lo, input logic [63:0] dv);
        exp_t e;
        logic signed [127:0] a, b, q, r, lim;
        int n;
        n = 8 << sz;
        case (sz)
            2'd0: begin a = {{112{lo[15]}}, lo[15:0]};             b = {{120{dv[7]}}, dv[7:0]}; end
            2'd1: begin a = {{96{hi[15]}}, hi[15:0], lo[15:0]};    b = {{112{dv[15]}}, dv[15:0]}; end
            2'd2: begin a = {{64{hi[31]}}, hi[31:0], lo[31:0]};    b = {{96{dv[31]}}, dv[31:0]}; end
            default: begin a = {hi, lo};                           b = {{64{dv[63]}}, dv}; end
        endcase
        e.sz = sz;
        e.q = '0;
        e.r = '0;
        if (b == 0) begin
            e.err = 1'b1;
        end else begin
            q = a / b;
            r = a % b;
            lim = 128'sd1 <<< (n - 1);
            e.err = (q >= lim) || (q < -lim);
            e.q = q[63:0];
            e.r = r[63:0];
        end
        return e;
    endfunction

    function automatic logic [63:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    // Scoreboard monitor: compare every completion against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R8", "done with no pending operation", 64'd1, 64'd0);
            end else begin
                exp_t  e;
                string t;
                e = sb.pop_front();
                t = tags.pop_front();
                chk(div_err == e.err, t, "div_err", 64'(div_err), 64'(e.err));
                chk(quot == e.q, t, "quot", quot, e.q);
                chk(rem == e.r, t, "rem", rem, e.r);
                if (e.sz == 2'd0)
                    chk(byte_res == {e.r[7:0], e.q[7:0]}, "R3", "byte_res",
                        64'(byte_res), 64'({e.r[7:0], e.q[7:0]}));
            end
        end
    end

    // Driver: queue the expectation, pulse start, optionally intrude while busy.
    task automatic run_op(input logic [1:0] sz, input logic [63:0] hi,
                          input logic [63:0] lo, input logic [63:0] dv,
                          input string tag, input bit inject);
        exp_t e;
        int cyc;
        e = model(sz, hi, lo, dv);
        if (!e.err) begin
            last_q = e.q;
            last_r = e.r;
        end else begin
            e.q = last_q;
            e.r = last_r;
        end
        sb.push_back(e);
        tags.push_back(tag);
        @(negedge clk);
        size_sel = sz; dvd_hi = hi; dvd_lo = lo; dvsr = dv; start = 1'b1;
        @(negedge clk);
        cyc = 1;
        chk(busy == 1'b1, "R7", "busy after start", 64'(busy), 64'd1);
        if (inject) begin
            size_sel = ~sz; dvd_hi = ~hi; dvd_lo = ~lo; dvsr = dv + 64'd3;
            @(negedge clk);
            cyc = 2;
        end
        start = 1'b0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc <= (8 << sz) + 3, "R7", "latency in negedges", 64'(cyc), 64'((8 << sz) + 3));
        @(negedge clk);
        chk(!done, "R7", "done pulse width", 64'(done), 64'd0);
        chk(!busy, "R7", "idle after done", 64'(busy), 64'd0);
        if (inject) begin
            repeat (2) @(negedge clk);
            chk(sb.size() == 0, "R8", "no extra operation", 64'(sb.size()), 64'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!busy && !done && !div_err, "R9", "control flags in reset",
            64'({busy, done, div_err}), 64'd0);
        chk(quot == 0 && rem == 0 && byte_res == 0, "R9", "results in reset", quot | rem, 64'd0);
        rst_n = 1'b1;

        // 8-bit mode
        run_op(2'd0, 64'd0, 64'd100, 64'd10, "R1", 1'b0);
        run_op(2'd0, 64'd0, 64'h0000_FFEF, 64'd5, "R1", 1'b0);          // -17 / 5
        run_op(2'd0, 64'd0, 64'd50, 64'h0000_00F9, "R2", 1'b0);         // 50 / -7
        run_op(2'd0, 64'd0, 64'h0000_FF38, 64'd15, "R3", 1'b0);         // -200 / 15
        run_op(2'd0, 64'd0, 64'h0000_FF80, 64'd1, "R4", 1'b0);          // -128 / 1
        run_op(2'd0, 64'd0, 64'd127, 64'd1, "R4", 1'b0);
        run_op(2'd0, 64'd0, 64'h0000_FF80, 64'h0000_00FF, "R6", 1'b0);  // -128 / -1
        run_op(2'd0, 64'd0, 64'd1000, 64'd2, "R6", 1'b0);
        run_op(2'd0, 64'd0, 64'd80, 64'h0000_0000_0000_FF00, "R5", 1'b0);
        run_op(2'd0, 64'hDEAD_BEEF_0123_4567, 64'h1234_5678_9ABC_0064,
               64'hFFFF_FFFF_FFFF_FF0A, "R10", 1'b0);
        // 16-bit mode
        run_op(2'd1, 64'h0000_0000_0000_FFFF, 64'd53191, 64'd1000, "R2", 1'b0);  // -12345 / 1000
        run_op(2'd1, 64'hAAAA_5555_0000_0000, 64'hFFFF_0000_0000_4E20,
               64'h1111_0000_0000_FED4, "R10", 1'b0);                            // 20000 / -300
        run_op(2'd1, 64'd0, 64'd32767, 64'd1, "R4", 1'b0);
        // 32-bit mode
        run_op(2'd2, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_F8A4_32EB, 64'd10000, "R1", 1'b1);
        run_op(2'd2, 64'd0, 64'd100000000, 64'h0000_0000_FFFF_D8F1, "R1", 1'b0);
        run_op(2'd2, 64'd0, 64'd7, 64'h1234_5678_0000_0000, "R5", 1'b0);
        // 64-bit mode
        run_op(2'd3, 64'd0, 64'd123456789012345, 64'd10000000, "R1", 1'b1);
        run_op(2'd3, {64{1'b1}}, 64'hFFFF_8FB7_79F2_2087, 64'd10000000, "R2", 1'b0);
        run_op(2'd3, {64{1'b1}}, 64'h8000_0000_0000_0000, 64'd1, "R4", 1'b0);
        run_op(2'd3, {64{1'b1}}, 64'h8000_0000_0000_0000, {64{1'b1}}, "R6", 1'b0);
        run_op(2'd3, 64'd5, 64'd0, 64'd3, "R6", 1'b0);
        run_op(2'd3, 64'd1, 64'd1, 64'd0, "R5", 1'b0);

        // Mixed sizes and signs from a pseudo-random stream
        for (int i = 0; i < 40; i++) begin
            logic [1:0]  sz;
            logic [63:0] lo, hi, dv;
            int n;
            sz = rnd() % 4;
            n = 8 << sz;
            lo = rnd();
            dv = rnd() >> (rnd() % 60);
            if (i % 2 == 0) hi = (sz == 2'd0) ? 64'd0 : {64{lo[n-1]}};
            else            hi = rnd();
            if (sz == 2'd0 && i % 4 == 0) lo = {48'd0, {8{lo[7]}}, lo[7:0]};
            if (rnd() % 2 == 1) dv = -dv;
            run_op(sz, hi, lo, dv, "R1", i % 5 == 0);
        end

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R7", "all operations completed", 64'(sb.size()), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule